// File: doc/BRIEF.md
# External Memory Window Controller

This block sits between a small signal processor's register file and its memory system. It provides a handful of access registers through which the processor moves 16-bit words to or from DRAM, cartridge ROM or internal program RAM. Each access register holds two independent transfer descriptors: one used by reads and one used by writes. A descriptor is an address paired with a 16-bit mode code. The mode code selects the target memory and how far the address advances after each transfer.

Descriptors are loaded through a control register in two steps. The first access to the control register captures an address. The second access captures a mode and leaves a configuration armed. The next access to an access register then stores the armed configuration into that register's read descriptor (on a read) or write descriptor (on a write). That arming access returns zero and moves no data.

After arming, accesses move data when the register is the always-transferring one, or when either of two processor status bits is set. Otherwise an access register behaves as a plain 16-bit storage cell. The memory request is combinational and is issued in the same cycle as the access. Read data from memory is passed straight through to the processor, and the descriptor address advances at the clock edge that ends the access. Arbitration and memory timing belong to the surrounding system.

Top module: `xmem_port_ctrl`

## Requirements
- R1: After reset no memory request, error or invalid-address pulse is issued, all descriptors and storage cells are zero, and an idle cycle (no strobe) gives read data 0.
- R2: Register index 5 is the control register. Its first access captures an address on a write, or returns the held address on a read. Its second access captures a mode on a write, or returns the held mode on a read. The second access arms a configuration.
- R3: While a configuration is armed, the next access to an access register (indices 0 to 4) loads {address, mode} into that register's read descriptor on a read, or into its write descriptor on a write. That access returns 0, issues no memory request and disarms.
- R4: Any access to an access register discards a half-finished control sequence, so the next control access captures an address again.
- R5: An access to an access register moves data only when its index is 4 or when status input st_bits is nonzero. Otherwise a write stores wr_data in that register and a read returns the stored value, with no memory request.
- R6: Write mode 0x0018 writes DRAM at the descriptor address (mem_tgt 0) and leaves the address unchanged. Write mode 0x0818 does the same and then adds 1.
- R7: Write mode 0x081C writes program RAM (mem_tgt 2) at the low 10 address bits and then adds 1. Write mode 0x101C does the same and then adds 2.
- R8: A program-RAM write whose address bits 15:10 differ from 100000 raises pram_addr_bad for that cycle. The write still takes place.
- R9: Read mode 0x0018 reads DRAM without advancing. Read mode 0x0818 advances by 1, and read mode 0x3018 advances by 32. Read data is mem_rdata in the same cycle.
- R10: Read mode 0x0809 reads ROM (mem_tgt 1) at word address {mode bits 3:0, 16-bit descriptor address} and then adds 1.
- R11: Address advances affect only the 16-bit descriptor address and wrap from 0xFFFF to 0x0000.
- R12: A transfer with an unrecognised mode issues no memory request, returns 0 and raises mode_err for that cycle.
- R13: The read and write descriptors of one register are independent. A write transfer does not move the read address, and a read transfer does not move the write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | 0 to 4 access registers, 5 control register |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle (both strobes high: no access) |
| wr_data | input | 16 | Data written by the processor |
| st_bits | input | 2 | Processor status bits enabling transfers on registers 0 to 3 |
| rd_data | output | 16 | Data returned to the processor |
| mem_req | output | 1 | Memory transfer request this cycle |
| mem_we | output | 1 | 1 for a write transfer |
| mem_tgt | output | 2 | Target: 0 DRAM, 1 ROM, 2 program RAM |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read from the target |
| mode_err | output | 1 | Unrecognised mode pulse |
| pram_addr_bad | output | 1 | Program-RAM address outside the expected window |

## Verification
The bench builds the block with its default parameters: five access registers, register 4 always transferring, a 10-bit program-RAM window based at 0x8000, and a 4-bit ROM extension. This makes it possible to check both transfer gating paths: register 4 with the status bits clear, and registers 1 to 3 with either status bit set. The full 20-bit ROM address is exposed to checking. The program-RAM window check is driven at both an in-window and an out-of-window address. The 16-bit descriptor width lets a short two-write sequence cross the 0xFFFF wrap.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      TGT_DRAM = 2'd0,
      TGT_ROM  = 2'd1,
      TGT_PRAM = 2'd2
   } tgt_e;

   typedef struct packed {
      logic       ok;
      tgt_e       tgt;
      logic [5:0] step;
   } mode_dec_t;

   localparam logic [15:0] WM_DRAM_HOLD = 16'h0018;
   localparam logic [15:0] WM_DRAM_INC1 = 16'h0818;
   localparam logic [15:0] WM_PRAM_INC1 = 16'h081C;
   localparam logic [15:0] WM_PRAM_INC2 = 16'h101C;
   localparam logic [15:0] RM_DRAM_HOLD = 16'h0018;
   localparam logic [15:0] RM_DRAM_INC1 = 16'h0818;
   localparam logic [15:0] RM_DRAM_I32  = 16'h3018;
   localparam logic [15:0] RM_ROM_INC1  = 16'h0809;

   function automatic mode_dec_t decode_mode(input logic [15:0] m, input logic is_wr);
      mode_dec_t d;
      d.ok   = 1'b1;
      d.tgt  = TGT_DRAM;
      d.step = 6'd0;
      if (is_wr) begin
         case (m)
            WM_DRAM_HOLD: d.step = 6'd0;
            WM_DRAM_INC1: d.step = 6'd1;
            WM_PRAM_INC1: begin d.tgt = TGT_PRAM; d.step = 6'd1; end
            WM_PRAM_INC2: begin d.tgt = TGT_PRAM; d.step = 6'd2; end
            default:      d.ok = 1'b0;
         endcase
      end else begin
         case (m)
            RM_DRAM_HOLD: d.step = 6'd0;
            RM_DRAM_INC1: d.step = 6'd1;
            RM_DRAM_I32:  d.step = 6'd32;
            RM_ROM_INC1:  begin d.tgt = TGT_ROM; d.step = 6'd1; end
            default:      d.ok = 1'b0;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/xmp_cfg_latch.sv
module xmp_cfg_latch
   import xmp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_acc,
   input  logic              ctrl_wr,
   input  logic [WORD_W-1:0] ctrl_wdata,
   input  logic              port_acc,
   output logic [WORD_W-1:0] cfg_addr,
   output logic [WORD_W-1:0] cfg_mode,
   output logic              cfg_pend,
   output logic [WORD_W-1:0] ctrl_rdata
);

   logic half_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_addr <= '0;
         cfg_mode <= '0;
         cfg_pend <= 1'b0;
         half_q   <= 1'b0;
      end else if (ctrl_acc) begin
         if (half_q) begin
            cfg_pend <= 1'b1;
            half_q   <= 1'b0;
            if (ctrl_wr) cfg_mode <= ctrl_wdata;
         end else begin
            half_q <= 1'b1;
            if (ctrl_wr) cfg_addr <= ctrl_wdata;
         end
      end else if (port_acc) begin
         half_q   <= 1'b0;
         cfg_pend <= 1'b0;
      end
   end

   assign ctrl_rdata = half_q ? cfg_mode : cfg_addr;

endmodule

// File: rtl/xmp_slot_bank.sv
module xmp_slot_bank
   import xmp_pkg::*;
#(
   parameter int NUM_REGS = 5,
   parameter int IDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              arm_rd,
   input  logic              arm_wr,
   input  logic [WORD_W-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_mode,
   input  logic              adv_rd,
   input  logic              adv_wr,
   input  logic [5:0]        step,
   input  logic              store_we,
   input  logic [WORD_W-1:0] store_wdata,
   output logic [WORD_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_mode,
   output logic [WORD_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_mode,
   output logic [WORD_W-1:0] store_q
);

   logic [WORD_W-1:0] ra_q [NUM_REGS];
   logic [WORD_W-1:0] rm_q [NUM_REGS];
   logic [WORD_W-1:0] wa_q [NUM_REGS];
   logic [WORD_W-1:0] wm_q [NUM_REGS];
   logic [WORD_W-1:0] sv_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      logic hit;
      assign hit = (idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ra_q[g] <= '0;
            rm_q[g] <= '0;
            wa_q[g] <= '0;
            wm_q[g] <= '0;
            sv_q[g] <= '0;
         end else if (hit) begin
            if (arm_rd) begin
               ra_q[g] <= cfg_addr;
               rm_q[g] <= cfg_mode;
            end else if (adv_rd) begin
               ra_q[g] <= ra_q[g] + WORD_W'(step);
            end
            if (arm_wr) begin
               wa_q[g] <= cfg_addr;
               wm_q[g] <= cfg_mode;
            end else if (adv_wr) begin
               wa_q[g] <= wa_q[g] + WORD_W'(step);
            end
            if (store_we) sv_q[g] <= store_wdata;
         end
      end
   end

   always_comb begin
      rd_addr = '0;
      rd_mode = '0;
      wr_addr = '0;
      wr_mode = '0;
      store_q = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == IDX_W'(i)) begin
            rd_addr = ra_q[i];
            rd_mode = rm_q[i];
            wr_addr = wa_q[i];
            wr_mode = wm_q[i];
            store_q = sv_q[i];
         end
      end
   end

endmodule

// File: rtl/xmp_xfer_unit.sv
module xmp_xfer_unit
   import xmp_pkg::*;
#(
   parameter int          PRAM_AW    = 10,
   parameter logic [15:0] PRAM_BASE  = 16'h8000,
   parameter bit          PRAM_CHECK = 1'b1,
   parameter int          ROM_HI_W   = 4,
   parameter int          MEM_AW     = WORD_W + ROM_HI_W
) (
   input  logic              go,
   input  logic              is_wr,
   input  logic [WORD_W-1:0] addr,
   input  logic [WORD_W-1:0] mode,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_tgt,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              mode_err,
   output logic              addr_bad,
   output logic              advance,
   output logic [5:0]        step
);

   mode_dec_t dec;

   always_comb begin
      dec       = decode_mode(mode, is_wr);
      mem_req   = go & dec.ok;
      mem_we    = mem_req & is_wr;
      mem_tgt   = mem_req ? dec.tgt : TGT_DRAM;
      mem_wdata = mem_we ? wdata : '0;
      mode_err  = go & ~dec.ok;
      advance   = mem_req;
      step      = dec.step;
      rdata     = (mem_req && !is_wr) ? mem_rdata : '0;
      mem_addr  = '0;
      if (mem_req) begin
         case (dec.tgt)
            TGT_ROM:  mem_addr = {mode[ROM_HI_W-1:0], addr};
            TGT_PRAM: mem_addr = MEM_AW'(addr[PRAM_AW-1:0]);
            default:  mem_addr = MEM_AW'(addr);
         endcase
      end
   end

   if (PRAM_CHECK) begin : g_win_chk
      logic [WORD_W-1:0] tag_have, tag_want;
      assign tag_have = addr >> PRAM_AW;
      assign tag_want = PRAM_BASE >> PRAM_AW;
      assign addr_bad = mem_req && (dec.tgt == TGT_PRAM) && (tag_have != tag_want);
   end else begin : g_no_chk
      assign addr_bad = 1'b0;
   end

endmodule

// File: rtl/xmem_port_ctrl.sv
module xmem_port_ctrl
   import xmp_pkg::*;
#(
   parameter int          NUM_REGS   = 5,
   parameter int          XFER_IDX   = 4,
   parameter int          PRAM_AW    = 10,
   parameter logic [15:0] PRAM_BASE  = 16'h8000,
   parameter bit          PRAM_CHECK = 1'b1,
   parameter int          ROM_HI_W   = 4,
   localparam int         IDX_W      = $clog2(NUM_REGS + 1),
   localparam int         MEM_AW     = WORD_W + ROM_HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        st_bits,
   output logic [WORD_W-1:0] rd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [1:0]        mem_tgt,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mode_err,
   output logic              pram_addr_bad
);

   localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_REGS);
   localparam logic [IDX_W-1:0] ALWAYS_IDX = IDX_W'(XFER_IDX);

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("NUM_REGS must be at least 1");
   end
   if (XFER_IDX < 0 || XFER_IDX >= NUM_REGS) begin : g_bad_xfer
      $error("XFER_IDX must name an access register");
   end
   if (PRAM_AW < 1 || PRAM_AW > WORD_W) begin : g_bad_pram
      $error("PRAM_AW must lie in 1..16");
   end
   if (ROM_HI_W < 1 || ROM_HI_W > 4) begin : g_bad_rom
      $error("ROM_HI_W must lie in 1..4");
   end

   logic              acc, is_wr, ctrl_hit, port_hit;
   logic              arm, xfer_go, plain;
   logic [WORD_W-1:0] cfg_addr, cfg_mode, ctrl_rdata;
   logic              cfg_pend;
   logic [WORD_W-1:0] rd_addr, rd_mode, wr_addr, wr_mode, store_q;
   logic [WORD_W-1:0] x_rdata;
   logic              x_adv;
   logic [5:0]        x_step;

   assign acc      = rd_en ^ wr_en;
   assign is_wr    = wr_en;
   assign ctrl_hit = acc && (reg_idx == CTRL_IDX);
   assign port_hit = acc && (reg_idx < CTRL_IDX);
   assign arm      = port_hit && cfg_pend;
   assign xfer_go  = port_hit && !cfg_pend && ((reg_idx == ALWAYS_IDX) || (st_bits != 2'b00));
   assign plain    = port_hit && !cfg_pend && !xfer_go;

   xmp_cfg_latch u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_acc   (ctrl_hit),
      .ctrl_wr    (is_wr),
      .ctrl_wdata (wr_data),
      .port_acc   (port_hit),
      .cfg_addr   (cfg_addr),
      .cfg_mode   (cfg_mode),
      .cfg_pend   (cfg_pend),
      .ctrl_rdata (ctrl_rdata)
   );

   xmp_slot_bank #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx         (reg_idx),
      .arm_rd      (arm && !is_wr),
      .arm_wr      (arm && is_wr),
      .cfg_addr    (cfg_addr),
      .cfg_mode    (cfg_mode),
      .adv_rd      (x_adv && !is_wr),
      .adv_wr      (x_adv && is_wr),
      .step        (x_step),
      .store_we    (plain && is_wr),
      .store_wdata (wr_data),
      .rd_addr     (rd_addr),
      .rd_mode     (rd_mode),
      .wr_addr     (wr_addr),
      .wr_mode     (wr_mode),
      .store_q     (store_q)
   );

   xmp_xfer_unit #(
      .PRAM_AW    (PRAM_AW),
      .PRAM_BASE  (PRAM_BASE),
      .PRAM_CHECK (PRAM_CHECK),
      .ROM_HI_W   (ROM_HI_W),
      .MEM_AW     (MEM_AW)
   ) u_xfer (
      .go        (xfer_go),
      .is_wr     (is_wr),
      .addr      (is_wr ? wr_addr : rd_addr),
      .mode      (is_wr ? wr_mode : rd_mode),
      .wdata     (wr_data),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_tgt   (mem_tgt),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rdata     (x_rdata),
      .mode_err  (mode_err),
      .addr_bad  (pram_addr_bad),
      .advance   (x_adv),
      .step      (x_step)
   );

   always_comb begin
      rd_data = '0;
      if (acc && !is_wr) begin
         if (ctrl_hit)    rd_data = ctrl_rdata;
         else if (plain)  rd_data = store_q;
         else if (xfer_go) rd_data = x_rdata;
      end
   end

endmodule

// File: rtl/xmp_checker.sv
module xmp_checker #(
   parameter int NUM_REGS = 5,
   parameter int XFER_IDX = 4,
   parameter int IDX_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] reg_idx,
   input logic             rd_en,
   input logic             wr_en,
   input logic [1:0]       st_bits,
   input logic [15:0]      rd_data,
   input logic             mem_req,
   input logic             mem_we,
   input logic [1:0]       mem_tgt,
   input logic             mode_err,
   input logic             pram_addr_bad,
   input logic             cfg_pend
);

   localparam logic [IDX_W-1:0] NREG = IDX_W'(NUM_REGS);
   localparam logic [IDX_W-1:0] XIDX = IDX_W'(XFER_IDX);

   logic port_acc;
   assign port_acc = (rd_en ^ wr_en) && (reg_idx < NREG);

   // R1: idle cycles are silent
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en || wr_en) |-> (!mem_req && rd_data == 16'h0 && !mode_err));

   // R5: requests only from gated access-register accesses
   p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (port_acc && (reg_idx == XIDX || st_bits != 2'b00)));

   // R3: arming access moves nothing and returns zero
   p_arm_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pend && port_acc) |-> (!mem_req && rd_data == 16'h0 && !mode_err));

   // R3: arming consumes the pending configuration
   p_arm_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pend && port_acc) |=> !cfg_pend);

   // R12: error and request never coincide
   p_err_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !mem_req);

   // R8: invalid window flag only on program RAM writes
   p_bad_on_pram_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pram_addr_bad |-> (mem_req && mem_we && mem_tgt == 2'd2));

   // R10: ROM is read-only
   p_rom_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_tgt == 2'd1) |-> !mem_we);

endmodule

bind xmem_port_ctrl xmp_checker #(
   .NUM_REGS (NUM_REGS),
   .XFER_IDX (XFER_IDX),
   .IDX_W    (IDX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_idx       (reg_idx),
   .rd_en         (rd_en),
   .wr_en         (wr_en),
   .st_bits       (st_bits),
   .rd_data       (rd_data),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_tgt       (mem_tgt),
   .mode_err      (mode_err),
   .pram_addr_bad (pram_addr_bad),
   .cfg_pend      (cfg_pend)
);

// File: tb/xmem_port_ctrl_tb.sv
module xmem_port_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  st_bits = '0;
   logic [15:0] rd_data;
   logic        mem_req, mem_we, mode_err, pram_addr_bad;
   logic [1:0]  mem_tgt;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   logic [15:0] o_rd;
   logic        o_req, o_we, o_err, o_bad;
   logic [1:0]  o_tgt;
   logic [19:0] o_addr;
   logic [15:0] o_wd;

   always #5 clk = ~clk;

   xmem_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .st_bits(st_bits), .rd_data(rd_data), .mem_req(mem_req),
      .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mode_err(mode_err), .pram_addr_bad(pram_addr_bad)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [2:0] idx, input bit w, input logic [15:0] d);
      @(negedge clk);
      reg_idx = idx; rd_en = !w; wr_en = w; wr_data = d;
      #2;
      o_rd = rd_data; o_req = mem_req; o_we = mem_we; o_tgt = mem_tgt;
      o_addr = mem_addr; o_wd = mem_wdata; o_err = mode_err; o_bad = pram_addr_bad;
      @(posedge clk);
      #1;
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic cfg(input logic [15:0] a, input logic [15:0] m);
      acc(3'd5, 1'b1, a);
      acc(3'd5, 1'b1, m);
   endtask

   task automatic t_reset;
      @(negedge clk); #2;
      chk("R1 idle rd_data", 32'(rd_data), 32'h0);
      chk("R1 idle req", 32'(mem_req), 32'h0);
      acc(3'd0, 1'b0, 16'h0);
      chk("R1 storage zero", 32'(o_rd), 32'h0);
      chk("R1 no req", 32'(o_req), 32'h0);
   endtask

   task automatic t_ctrl;
      acc(3'd5, 1'b1, 16'h4321);
      acc(3'd5, 1'b1, 16'h0818);
      acc(3'd1, 1'b0, 16'h0);       // consumes armed config
      acc(3'd5, 1'b0, 16'h0);
      chk("R2 ctrl read address", 32'(o_rd), 32'h4321);
      acc(3'd5, 1'b0, 16'h0);
      chk("R2 ctrl read mode", 32'(o_rd), 32'h0818);
      acc(3'd1, 1'b0, 16'h0);
      chk("R3 arm returns 0", 32'(o_rd), 32'h0);
      chk("R3 arm no req", 32'(o_req), 32'h0);
   endtask

   task automatic t_storage;
      st_bits = 2'b00;
      acc(3'd1, 1'b1, 16'hBEEF);
      chk("R5 plain write no req", 32'(o_req), 32'h0);
      acc(3'd1, 1'b0, 16'h0);
      chk("R5 plain read back", 32'(o_rd), 32'hBEEF);
      chk("R5 plain read no req", 32'(o_req), 32'h0);
   endtask

   task automatic t_dram_wr;
      cfg(16'h0100, 16'h0818);
      acc(3'd4, 1'b1, 16'h1111);
      chk("R3 arm write no req", 32'(o_req), 32'h0);
      acc(3'd4, 1'b1, 16'hAAAA);
      chk("R6 req", 32'(o_req), 32'h1);
      chk("R6 we", 32'(o_we), 32'h1);
      chk("R6 tgt", 32'(o_tgt), 32'h0);
      chk("R6 addr", 32'(o_addr), 32'h00100);
      chk("R6 wdata", 32'(o_wd), 32'hAAAA);
      acc(3'd4, 1'b1, 16'hBBBB);
      chk("R6 inc1 addr", 32'(o_addr), 32'h00101);
      st_bits = 2'b01;
      cfg(16'h0777, 16'h0018);
      acc(3'd3, 1'b1, 16'h0);
      acc(3'd3, 1'b1, 16'h1234);
      chk("R5 st gated req", 32'(o_req), 32'h1);
      acc(3'd3, 1'b1, 16'h1235);
      chk("R6 hold addr", 32'(o_addr), 32'h00777);
      st_bits = 2'b00;
      acc(3'd3, 1'b1, 16'h5555);
      chk("R5 st clear no req", 32'(o_req), 32'h0);
   endtask

   task automatic t_pram;
      cfg(16'h8005, 16'h101C);
      acc(3'd4, 1'b1, 16'h0);
      acc(3'd4, 1'b1, 16'hC0DE);
      chk("R7 tgt", 32'(o_tgt), 32'h2);
      chk("R7 addr", 32'(o_addr), 32'h00005);
      chk("R8 in window", 32'(o_bad), 32'h0);
      acc(3'd4, 1'b1, 16'hC0DF);
      chk("R7 inc2 addr", 32'(o_addr), 32'h00007);
      cfg(16'h4403, 16'h081C);
      acc(3'd4, 1'b1, 16'h0);
      acc(3'd4, 1'b1, 16'h0001);
      chk("R8 out of window", 32'(o_bad), 32'h1);
      chk("R8 still writes", 32'(o_req), 32'h1);
      chk("R7 low bits", 32'(o_addr), 32'h00003);
      acc(3'd4, 1'b1, 16'h0002);
      chk("R7 inc1 addr", 32'(o_addr), 32'h00004);
   endtask

   task automatic t_dram_rd;
      cfg(16'h0200, 16'h3018);
      acc(3'd4, 1'b0, 16'h0);
      chk("R3 read arm 0", 32'(o_rd), 32'h0);
      mem_rdata = 16'h5A5A;
      acc(3'd4, 1'b0, 16'h0);
      chk("R9 rdata", 32'(o_rd), 32'h5A5A);
      chk("R9 addr", 32'(o_addr), 32'h00200);
      chk("R9 read we", 32'(o_we), 32'h0);
      acc(3'd4, 1'b0, 16'h0);
      chk("R9 inc32 addr", 32'(o_addr), 32'h00220);
      cfg(16'h0300, 16'h0018);
      acc(3'd4, 1'b0, 16'h0);
      acc(3'd4, 1'b0, 16'h0);
      acc(3'd4, 1'b0, 16'h0);
      chk("R9 hold addr", 32'(o_addr), 32'h00300);
   endtask

   task automatic t_rom;
      cfg(16'h1234, 16'h0809);
      acc(3'd4, 1'b0, 16'h0);
      mem_rdata = 16'h9876;
      acc(3'd4, 1'b0, 16'h0);
      chk("R10 tgt", 32'(o_tgt), 32'h1);
      chk("R10 addr", 32'(o_addr), 32'h91234);
      chk("R10 rdata", 32'(o_rd), 32'h9876);
      acc(3'd4, 1'b0, 16'h0);
      chk("R10 inc addr", 32'(o_addr), 32'h91235);
   endtask

   task automatic t_wrap;
      cfg(16'hFFFF, 16'h0818);
      acc(3'd4, 1'b1, 16'h0);
      acc(3'd4, 1'b1, 16'h0001);
      chk("R11 top addr", 32'(o_addr), 32'h0FFFF);
      acc(3'd4, 1'b1, 16'h0002);
      chk("R11 wrapped addr", 32'(o_addr), 32'h00000);
   endtask

   task automatic t_badmode;
      cfg(16'h0010, 16'h0123);
      acc(3'd4, 1'b0, 16'h0);
      mem_rdata = 16'hFFFF;
      acc(3'd4, 1'b0, 16'h0);
      chk("R12 err", 32'(o_err), 32'h1);
      chk("R12 no req", 32'(o_req), 32'h0);
      chk("R12 rd 0", 32'(o_rd), 32'h0);
   endtask

   task automatic t_indep;
      st_bits = 2'b10;
      cfg(16'h0300, 16'h0818);
      acc(3'd2, 1'b0, 16'h0);
      cfg(16'h0400, 16'h0018);
      acc(3'd2, 1'b1, 16'h0);
      acc(3'd2, 1'b0, 16'h0);
      chk("R13 read slot", 32'(o_addr), 32'h00300);
      acc(3'd2, 1'b1, 16'h7777);
      chk("R13 write slot", 32'(o_addr), 32'h00400);
      acc(3'd2, 1'b0, 16'h0);
      chk("R13 read advanced alone", 32'(o_addr), 32'h00301);
      st_bits = 2'b00;
   endtask

   task automatic t_clear_half;
      acc(3'd5, 1'b1, 16'h0055);
      acc(3'd0, 1'b0, 16'h0);
      cfg(16'h0066, 16'h0018);
      acc(3'd4, 1'b0, 16'h0);
      acc(3'd4, 1'b0, 16'h0);
      chk("R4 fresh address", 32'(o_addr), 32'h00066);
      chk("R4 transfer", 32'(o_req), 32'h1);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_storage();
      t_dram_wr();
      t_pram();
      t_dram_rd();
      t_rom();
      t_wrap();
      t_badmode();
      t_indep();
      t_clear_half();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule